// File: doc/BRIEF.md
# Windowed Watchdog Timer with Ordered Service Key

This block supervises software by counting oscillator clock cycles from the moment it was last restarted. Software keeps it quiet by writing a two-byte key to the service register before the count runs out. When the count expires first, or when software services it wrongly, the block drives a fixed-length system reset pulse. It also raises a flag naming itself as the reset cause, and it presents the watchdog's reset vector address.

A control register selects the timeout through a 3-bit rate code and enables an optional window mode. In window mode a service byte is accepted only once three quarters of the period have elapsed. In user mode the control register takes one write after reset; in test mode it takes any number. Every control write, accepted or not, restarts the count.

The behaviour is a four-state machine:
- IDLE: disabled.
- ARMED: counting, waiting for the first key byte.
- KEYED: counting, first byte seen, waiting for the second.
- FIRE: driving the reset pulse.

The transitions are:
- IDLE→ARMED on a control write with a nonzero rate.
- ARMED→KEYED on an accepted first key byte.
- KEYED→ARMED on the second key byte, which restarts the count, or on a wrong second byte, which abandons the key.
- ARMED/KEYED→IDLE on a control write that makes the rate zero.
- ARMED/KEYED→FIRE on expiry, on a wrong first byte, or on a service byte sent while the window is closed.
- FIRE→IDLE after the last pulse cycle.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_n` is released, `sys_rst` is 0, `wdt_src` is 0 and `rst_vec` is 16'hFFFE. With no register writes, `sys_rst` never rises.
- R2: While the rate code is 3'b000, the watchdog is disabled. No reset is produced, and service writes (`wr_sel`=1) of any value are ignored.
- R3: A control write (`wr_sel`=0) takes the rate from `wr_data[2:0]` and the window-mode bit from `wr_data[7]`. With a rate r≠0, `sys_rst` rises exactly 2^(BASE_EXP+2r) clock edges after the edge that sampled the write.
- R4: A service write of 8'h55 followed by a service write of 8'hAA restarts the count. `sys_rst` then rises 2^(BASE_EXP+2r) edges after the edge that sampled 8'hAA.
- R5: While the block waits for the first key byte, a service write of any value other than 8'h55 makes `sys_rst` high from the next edge.
- R6: After 8'h55, a service value other than 8'hAA abandons the key without a reset and without restarting the count. The original expiry time stands.
- R7: With window mode set, a service byte sampled while the count is below 3/4 of the period raises `sys_rst` from the next edge. A byte sampled at or above 3/4 of the period is accepted.
- R8: With `test_mode`=0, only the first control write after reset changes the rate and window bit. A later control write changes neither, but still restarts the count.
- R9: With `test_mode`=1, every control write changes the configuration; writing rate 3'b000 disables the watchdog.
- R10: A reset pulse lasts exactly PULSE_LEN (64) cycles. From its first cycle `wdt_src` stays 1 and `rst_vec` reads 16'hFFFA, until `rst_n` is asserted. After the pulse the watchdog is disabled and the control register takes a user-mode write again.
- R11: An accepted 8'hAA sampled on the same edge at which the count would expire restarts the count instead of producing a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| test_mode | input | 1 | 1 allows repeated control writes |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| wr_sel | input | 1 | 0 = control register, 1 = service register |
| wr_data | input | 8 | Write data; control uses bit 7 (window mode) and bits 2:0 (rate) |
| sys_rst | output | 1 | System reset pulse, active high |
| wdt_src | output | 1 | Sticky flag: the watchdog caused a reset |
| rst_vec | output | 16 | Reset vector address: 16'hFFFA after a watchdog reset, else 16'hFFFE |

## Verification
A service byte can arrive on the same edge at which the count expires, so key handling and timeout compete within one cycle. The bench provokes this by timing the 8'h55 for the cycle before expiry and the 8'hAA for the expiry edge itself. It judges the result by the absence of a pulse on that edge and by the next pulse falling one full period later. The window boundary is probed one count below and exactly at the three-quarter point. The bench also mixes in randomly placed service attempts, whose pass or fail outcome bench functions predict from the rate, the window bit and the service time.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_KEYED,
        ST_FIRE
    } wdt_state_e;

    localparam int          RATE_W     = 3;
    localparam int          WIN_BIT    = 7;
    localparam logic [7:0]  KEY_FIRST  = 8'h55;
    localparam logic [7:0]  KEY_SECOND = 8'hAA;
    localparam logic [15:0] VEC_WDT    = 16'hFFFA;
    localparam logic [15:0] VEC_POR    = 16'hFFFE;
    localparam logic        SEL_CTRL   = 1'b0;
    localparam logic        SEL_SVC    = 1'b1;

endpackage

// File: rtl/wdt_keyed_ctrl.sv
module wdt_keyed_ctrl
    import wdt_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              test_mode,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              win_in,
    input  logic              clr,
    output logic [RATE_W-1:0] rate_q,
    output logic [RATE_W-1:0] rate_d,
    output logic              win_q,
    output logic              locked_q
);

    logic acc;
    logic win_d;
    logic lock_d;

    always_comb begin
        acc    = we && (test_mode || !locked_q);
        rate_d = rate_q;
        win_d  = win_q;
        lock_d = locked_q;
        if (clr) begin
            rate_d = '0;
            win_d  = 1'b0;
            lock_d = 1'b0;
        end else if (acc) begin
            rate_d = rate_in;
            win_d  = win_in;
            lock_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= '0;
            win_q    <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            rate_q   <= rate_d;
            win_q    <= win_d;
            locked_q <= lock_d;
        end
    end

endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
    import wdt_keyed_pkg::*;
#(
    parameter int BASE_EXP = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              expire,
    output logic              win_open
);

    localparam int MAX_EXP = BASE_EXP + 2 * ((1 << RATE_W) - 1);
    localparam int CW      = MAX_EXP + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [CW-1:0] win_start;

    always_comb begin
        lim       = CW'(1) << (BASE_EXP + 2 * int'(rate));
        win_start = lim - (lim >> 2);
        expire    = run && (cnt == lim - CW'(1));
        win_open  = (cnt >= win_start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/wdt_keyed_fsm.sv
module wdt_keyed_fsm
    import wdt_keyed_pkg::*;
#(
    parameter int PULSE_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       svc_wr,
    input  logic [7:0] wdata,
    input  logic       en_d,
    input  logic       win_mode,
    input  logic       win_open,
    input  logic       expire,
    output wdt_state_e st,
    output logic       restart,
    output logic       go_fire,
    output logic       run,
    output logic       sys_rst,
    output logic       wdt_src
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    wdt_state_e    st_d;
    logic [PW-1:0] pcnt;
    logic          early;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pcnt    <= '0;
            wdt_src <= 1'b0;
        end else begin
            st      <= st_d;
            pcnt    <= (st == ST_FIRE) ? pcnt + PW'(1) : '0;
            wdt_src <= wdt_src | go_fire;
        end
    end

    always_comb begin
        st_d    = st;
        restart = 1'b0;
        go_fire = 1'b0;
        early   = win_mode && !win_open;
        unique case (st)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    restart = 1'b1;
                    if (en_d) st_d = ST_ARMED;
                end
            end
            ST_ARMED, ST_KEYED: begin
                if (ctrl_wr) begin
                    restart = 1'b1;
                    st_d    = en_d ? ST_ARMED : ST_IDLE;
                end else if (svc_wr) begin
                    if (early) begin
                        go_fire = 1'b1;
                    end else if (st == ST_ARMED) begin
                        if (wdata != KEY_FIRST || expire) go_fire = 1'b1;
                        else                              st_d    = ST_KEYED;
                    end else if (wdata == KEY_SECOND) begin
                        restart = 1'b1;
                        st_d    = ST_ARMED;
                    end else if (expire) begin
                        go_fire = 1'b1;
                    end else begin
                        st_d = ST_ARMED;
                    end
                end else if (expire) begin
                    go_fire = 1'b1;
                end
            end
            ST_FIRE: begin
                if (pcnt == PW'(PULSE_LEN - 1)) st_d = ST_IDLE;
            end
        endcase
        if (go_fire) st_d = ST_FIRE;
    end

    always_comb begin
        sys_rst = (st == ST_FIRE);
        run     = (st == ST_ARMED) || (st == ST_KEYED);
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int BASE_EXP  = 9,
    parameter int PULSE_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        test_mode,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    output logic        sys_rst,
    output logic        wdt_src,
    output logic [15:0] rst_vec
);

    wdt_state_e        st;
    logic              ctrl_we;
    logic              svc_we;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] rate_d;
    logic              win_q;
    logic              locked_q;
    logic              restart;
    logic              go_fire;
    logic              run;
    logic              expire;
    logic              win_open;

    always_comb begin
        ctrl_we = wr_en && (wr_sel == SEL_CTRL) && (st != ST_FIRE);
        svc_we  = wr_en && (wr_sel == SEL_SVC);
        rst_vec = wdt_src ? VEC_WDT : VEC_POR;
    end

    wdt_keyed_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctrl_we),
        .test_mode (test_mode),
        .rate_in   (wr_data[RATE_W-1:0]),
        .win_in    (wr_data[WIN_BIT]),
        .clr       (go_fire),
        .rate_q    (rate_q),
        .rate_d    (rate_d),
        .win_q     (win_q),
        .locked_q  (locked_q)
    );

    wdt_keyed_timer #(.BASE_EXP(BASE_EXP)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (restart),
        .rate     (rate_q),
        .expire   (expire),
        .win_open (win_open)
    );

    wdt_keyed_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_we),
        .svc_wr   (svc_we),
        .wdata    (wr_data),
        .en_d     (rate_d != '0),
        .win_mode (win_q),
        .win_open (win_open),
        .expire   (expire),
        .st       (st),
        .restart  (restart),
        .go_fire  (go_fire),
        .run      (run),
        .sys_rst  (sys_rst),
        .wdt_src  (wdt_src)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
#(
    parameter int PULSE_LEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_mode,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [7:0]        wr_data,
    input logic              sys_rst,
    input logic              wdt_src,
    input logic [15:0]       rst_vec,
    input wdt_state_e        st,
    input logic [RATE_W-1:0] rate_q,
    input logic              locked_q
);

    localparam int PCW = $clog2(PULSE_LEN + 2);

    logic [PCW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= '0;
        else        hi_cnt <= sys_rst ? hi_cnt + PCW'(1) : '0;
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> !sys_rst); // R2

    AST_BAD_FIRST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SVC && st == ST_ARMED && wr_data != KEY_FIRST) |=> sys_rst); // R5

    AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && locked_q && wr_en && wr_sel == SEL_CTRL) |=> $stable(rate_q)); // R8

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (hi_cnt < PCW'(PULSE_LEN))); // R10

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (hi_cnt == PCW'(PULSE_LEN))); // R10

    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_src |=> wdt_src); // R10

    AST_VEC_DURING_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (wdt_src && rst_vec == VEC_WDT)); // R10

endmodule

bind wdt_keyed wdt_keyed_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sys_rst   (sys_rst),
    .wdt_src   (wdt_src),
    .rst_vec   (rst_vec),
    .st        (st),
    .rate_q    (rate_q),
    .locked_q  (locked_q)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/100ps
module wdt_keyed_test;

    localparam int BE    = 5;
    localparam int PLEN  = 64;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        sys_rst;
    logic        wdt_src;
    logic [15:0] rst_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_keyed #(.BASE_EXP(BE), .PULSE_LEN(PLEN)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sys_rst   (sys_rst),
        .wdt_src   (wdt_src),
        .rst_vec   (rst_vec)
    );

    function automatic int period(int r);
        return 1 << (BE + 2 * r);
    endfunction

    function automatic bit in_window(int r, int cnt);
        return cnt >= period(r) - period(r) / 4;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
    endtask

    task automatic expect_fire_after(string tag, int k);
        waitn(k - 1);
        chk({tag, " before expiry"}, 16'(sys_rst), 16'd0);
        waitn(1);
        chk({tag, " at expiry"}, 16'(sys_rst), 16'd1);
    endtask

    task automatic finish_pulse(string tag);
        waitn(PLEN);
        chk({tag, " pulse ended"}, 16'(sys_rst), 16'd0);
    endtask

    initial begin
        int t1;
        int t2;
        int seed;
        int r;
        int d;
        int junk;
        bit win;
        bit bad;
        bit ok;
        t1 = period(1);
        t2 = period(2);
        seed = 20240611;
        junk = $urandom(seed);
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 sys_rst", 16'(sys_rst), 16'd0);
        chk("R1 wdt_src", 16'(wdt_src), 16'd0);
        chk("R1 rst_vec", rst_vec, 16'hFFFE);
        waitn(3000);
        chk("R1 quiet without writes", 16'(sys_rst), 16'd0);
        // R2 disabled ignores service
        wr(1'b1, 8'h33);
        chk("R2 bad byte while disabled", 16'(sys_rst), 16'd0);
        waitn(2);
        chk("R2 still quiet", 16'(sys_rst), 16'd0);

        // R3 timeout and R10 pulse shape
        wr(1'b0, 8'h01);
        expect_fire_after("R3 rate1", t1);
        chk("R10 src set", 16'(wdt_src), 16'd1);
        chk("R10 vector", rst_vec, 16'hFFFA);
        waitn(PLEN - 1);
        chk("R10 last pulse cycle", 16'(sys_rst), 16'd1);
        waitn(1);
        chk("R10 pulse length", 16'(sys_rst), 16'd0);
        chk("R10 vector kept", rst_vec, 16'hFFFA);
        wr(1'b0, 8'h02);
        expect_fire_after("R10 rewrite after pulse R3 rate2", t2);
        finish_pulse("R3");

        // R8 write once, counter reinitialised
        do_reset();
        chk("R1 src cleared by reset", 16'(wdt_src), 16'd0);
        wr(1'b0, 8'h01);
        waitn(50);
        wr(1'b0, 8'h00);
        expect_fire_after("R8 locked rewrite", t1);
        finish_pulse("R8");

        // R9 test mode rewrite
        do_reset();
        test_mode = 1'b1;
        wr(1'b0, 8'h01);
        waitn(5);
        wr(1'b0, 8'h00);
        waitn(600);
        chk("R9 disabled by test write", 16'(sys_rst), 16'd0);
        test_mode = 1'b0;

        // R4 key restarts count
        do_reset();
        wr(1'b0, 8'h01);
        waitn(60);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        chk("R4 no reset on key", 16'(sys_rst), 16'd0);
        expect_fire_after("R4 restarted", t1);
        finish_pulse("R4");

        // R5 wrong first byte
        do_reset();
        wr(1'b0, 8'h01);
        waitn(10);
        wr(1'b1, 8'h3C);
        chk("R5 immediate reset", 16'(sys_rst), 16'd1);
        waitn(PLEN - 1);
        chk("R5 pulse held", 16'(sys_rst), 16'd1);
        waitn(1);
        chk("R5 pulse ended", 16'(sys_rst), 16'd0);

        // R6 abandoned key keeps original expiry
        do_reset();
        wr(1'b0, 8'h01);
        waitn(20);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h12);
        chk("R6 no reset on abandon", 16'(sys_rst), 16'd0);
        expect_fire_after("R6 original expiry", t1 - 22);
        finish_pulse("R6");

        // R7 window boundary
        do_reset();
        wr(1'b0, 8'h81);
        waitn(t1 * 3 / 4 - 1);
        wr(1'b1, 8'h55);
        chk("R7 one count early", 16'(sys_rst), 16'd1);
        finish_pulse("R7");
        do_reset();
        wr(1'b0, 8'h81);
        waitn(t1 * 3 / 4);
        wr(1'b1, 8'h55);
        chk("R7 at window start", 16'(sys_rst), 16'd0);
        wr(1'b1, 8'hAA);
        chk("R7 key accepted", 16'(sys_rst), 16'd0);
        expect_fire_after("R7 restarted", t1);
        finish_pulse("R7");

        // R11 key completion on expiry edge
        do_reset();
        wr(1'b0, 8'h01);
        waitn(t1 - 2);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        chk("R11 restart beats expiry", 16'(sys_rst), 16'd0);
        expect_fire_after("R11 next period", t1);
        finish_pulse("R11");

        // random service attempts in test mode (R4 R5 R7)
        test_mode = 1'b1;
        for (int i = 0; i < 14; i++) begin
            r   = 1 + int'($urandom % 3);
            win = 1'($urandom % 2);
            bad = ($urandom % 5) == 0;
            d   = int'($urandom % (period(r) - 2));
            wr(1'b0, {win, 4'b0000, 3'(r)});
            waitn(d);
            if (bad) begin
                wr(1'b1, 8'h5A);
                chk("R5 random bad byte", 16'(sys_rst), 16'd1);
                finish_pulse("R5 random");
            end else begin
                ok = !win || in_window(r, d);
                wr(1'b1, 8'h55);
                chk("R7 random window", 16'(sys_rst), 16'(!ok));
                if (!ok) begin
                    finish_pulse("R7 random");
                end else begin
                    wr(1'b1, 8'hAA);
                    chk("R4 random key", 16'(sys_rst), 16'd0);
                    expect_fire_after("R4 random restart", period(r));
                    finish_pulse("R4 random");
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule